// File: doc/BRIEF.md
# Bitfield Extract and Deposit Unit

This block is the bitfield execution slice of a 32-bit integer pipeline. Each accepted operation takes one source word, a field descriptor and an operation code, and returns one result word registered on the next clock edge. The descriptor names a field by its lowest bit position and its length. It is taken either from a second source register or from an immediate, and both carry the same packed 10-bit layout.

The unit pulls a field out of a word, either zero-filled or sign-filled. It can also drop the low bits of a word into a field position with zeros around it. A field length of zero stands for the whole word. That choice makes logical left shift, logical right shift and arithmetic right shift special cases of these three operations, so no separate shifter is needed. Six AND-style masking forms complete the set. Register file access, decode and condition flags belong to the surrounding pipeline.

Top module: `bitfield_unit`

## Requirements
- R1: After reset `outValid` is 0 and `result` is 0. An operation presented with `inValid` high produces its result on `result`, with `outValid` high, after exactly one rising clock edge.
- R2: The descriptor is `srcB[9:0]` when `immSel` is 0 and `immField[9:0]` when `immSel` is 1. Bits [4:0] give the offset `o` and bits [9:5] give the width code. All other descriptor bits have no effect on field operations.
- R3: A width code of 0 means a width of 32.
- R4: Opcode 0 (unsigned extract) returns bits `o` upward of `srcA`, up to width `w`, right-justified and zero-filled. Field bits that would lie above bit 31 are absent.
- R5: Opcode 1 (signed extract) returns the same field sign-filled from its top present bit. When `o+w` exceeds 32, the sign comes from `srcA[31]`.
- R6: Opcode 2 (deposit) places the low `w` bits of `srcA` starting at bit `o`, with zeros elsewhere. Bits that would land above bit 31 are dropped.
- R7: With width code 0, opcode 0 equals `srcA` logically shifted right by `o`, opcode 1 equals an arithmetic right shift by `o`, and opcode 2 equals a logical left shift by `o`.
- R8: Opcode 3 returns `srcA & srcB`. Opcode 4 returns `srcA & ~srcB`.
- R9: Opcode 5 returns `srcA & {16'hFFFF, immField}`. Opcode 6 returns `srcA & {immField, 16'hFFFF}`.
- R10: Opcode 7 returns `srcA & {16'h0, immField}`. Opcode 8 returns `srcA & {immField, 16'h0}`.
- R11: Opcodes 9 to 15 return 0. While `inValid` is low, `outValid` is 0 and `result` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation present this cycle |
| opSel | input | 4 | Operation code |
| srcA | input | 32 | Source word |
| srcB | input | 32 | Second register: descriptor or AND operand |
| immField | input | 16 | Immediate: descriptor or mask half |
| immSel | input | 1 | 1 selects the immediate descriptor |
| outValid | output | 1 | Result valid |
| result | output | 32 | Registered result |

## Verification
Properties check on every cycle that the one-edge latency holds, that the result holds when idle, that deposit leaves every bit below the offset clear, and that extract results are clean above the field: zero-filled for the unsigned form and a consistent sign fill for the signed form. The exact field contents can only be shown by the bench's scenarios, which compare against a bit-by-bit reference model. These scenarios cover descriptor selection with junk upper bits, the width-zero shift equivalences, fields that run past bit 31, the six mask forms and the undefined opcodes.

// File: rtl/bfPkg.sv
package bfPkg;
  localparam int DATA_W = 32;

  typedef enum logic [3:0] {
    OP_EXTU  = 4'd0,
    OP_EXTS  = 4'd1,
    OP_MAKE  = 4'd2,
    OP_AND   = 4'd3,
    OP_ANDN  = 4'd4,
    OP_ANDIL = 4'd5,
    OP_ANDIH = 4'd6,
    OP_MSKL  = 4'd7,
    OP_MSKH  = 4'd8
  } bfOpE;

  typedef enum logic [2:0] {
    MK_NONE  = 3'd0,
    MK_REG   = 3'd1,
    MK_REGN  = 3'd2,
    MK_IMMLO = 3'd3,
    MK_IMMHI = 3'd4,
    MK_ZLO   = 3'd5,
    MK_ZHI   = 3'd6
  } maskKindE;

  typedef struct packed {
    logic     loadEn;
    logic     doExtract;
    logic     signExt;
    logic     doMake;
    logic     doMask;
    maskKindE maskKind;
  } bfCtrlS;
endpackage

// File: rtl/bfCtrl.sv
module bfCtrl
  import bfPkg::*;
(
  input  logic       inValid,
  input  logic [3:0] opSel,
  output bfCtrlS     ctrl
);
  always_comb begin
    ctrl = '{loadEn: inValid, doExtract: 1'b0, signExt: 1'b0,
             doMake: 1'b0, doMask: 1'b0, maskKind: MK_NONE};
    case (opSel)
      OP_EXTU:  ctrl.doExtract = 1'b1;
      OP_EXTS:  begin ctrl.doExtract = 1'b1; ctrl.signExt = 1'b1; end
      OP_MAKE:  ctrl.doMake = 1'b1;
      OP_AND:   begin ctrl.doMask = 1'b1; ctrl.maskKind = MK_REG;   end
      OP_ANDN:  begin ctrl.doMask = 1'b1; ctrl.maskKind = MK_REGN;  end
      OP_ANDIL: begin ctrl.doMask = 1'b1; ctrl.maskKind = MK_IMMLO; end
      OP_ANDIH: begin ctrl.doMask = 1'b1; ctrl.maskKind = MK_IMMHI; end
      OP_MSKL:  begin ctrl.doMask = 1'b1; ctrl.maskKind = MK_ZLO;   end
      OP_MSKH:  begin ctrl.doMask = 1'b1; ctrl.maskKind = MK_ZHI;   end
      default:  ;
    endcase
  end
endmodule

// File: rtl/bfDatapath.sv
module bfDatapath
  import bfPkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  bfCtrlS            ctrl,
  input  logic [DW-1:0]     srcA,
  input  logic [DW-1:0]     srcB,
  input  logic [DW/2-1:0]   immField,
  input  logic              immSel,
  output logic              outValid,
  output logic [DW-1:0]     result
);
  localparam int POS_W  = $clog2(DW);
  localparam int SPEC_W = 2 * POS_W;
  localparam int IMM_W  = DW / 2;
  localparam int CNT_W  = POS_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DW);
  localparam logic [DW-1:0]    ONES = {DW{1'b1}};

  logic [SPEC_W-1:0] spec;
  logic [POS_W-1:0]  offset;
  logic [POS_W-1:0]  widthCode;
  logic [CNT_W-1:0]  widthFull, room, effW;
  logic [DW-1:0]     fieldMask, effMask, shifted, extU, extS, makeV, maskV, nextRes;
  logic [DW-1:0]     belowOff;
  logic              signBit;

  assign spec      = immSel ? immField[SPEC_W-1:0] : srcB[SPEC_W-1:0];
  assign offset    = spec[POS_W-1:0];
  assign widthCode = spec[SPEC_W-1:POS_W];
  assign widthFull = (widthCode == '0) ? FULL : {1'b0, widthCode};
  assign room      = FULL - {1'b0, offset};
  assign effW      = (widthFull > room) ? room : widthFull;

  assign fieldMask = ONES >> (FULL - widthFull);
  assign effMask   = ONES >> (FULL - effW);
  assign shifted   = srcA >> offset;
  assign extU      = shifted & fieldMask;
  assign signBit   = shifted[POS_W'(effW - 1'b1)];
  assign extS      = signBit ? (extU | ~effMask) : extU;
  assign makeV     = (srcA & fieldMask) << offset;
  assign belowOff  = ~(ONES << offset);

  always_comb begin
    case (ctrl.maskKind)
      MK_REG:   maskV = srcA & srcB;
      MK_REGN:  maskV = srcA & ~srcB;
      MK_IMMLO: maskV = srcA & {{IMM_W{1'b1}}, immField};
      MK_IMMHI: maskV = srcA & {immField, {IMM_W{1'b1}}};
      MK_ZLO:   maskV = srcA & {{IMM_W{1'b0}}, immField};
      MK_ZHI:   maskV = srcA & {immField, {IMM_W{1'b0}}};
      default:  maskV = '0;
    endcase
  end

  always_comb begin
    nextRes = '0;
    if (ctrl.doExtract)   nextRes = ctrl.signExt ? extS : extU;
    else if (ctrl.doMake) nextRes = makeV;
    else if (ctrl.doMask) nextRes = maskV;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= ctrl.loadEn;
      if (ctrl.loadEn) result <= nextRes;
    end
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadEn |=> outValid);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.loadEn |=> (!outValid && $stable(result)));
  // R6
  make_low_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadEn && ctrl.doMake) |=> ((result & $past(belowOff)) == '0));
  // R4
  extu_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadEn && ctrl.doExtract && !ctrl.signExt) |=> ((result >> $past(effW)) == '0));
  // R5
  exts_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadEn && ctrl.doExtract && ctrl.signExt && (effW < FULL)) |=>
      (result[DW-1] ? (((~result) >> $past(effW)) == '0)
                    : ((result >> $past(effW)) == '0)));
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [3:0]  opSel,
  input  logic [31:0] srcA,
  input  logic [31:0] srcB,
  input  logic [15:0] immField,
  input  logic        immSel,
  output logic        outValid,
  output logic [31:0] result
);
  bfCtrlS ctrl;

  bfCtrl uCtrl (
    .inValid (inValid),
    .opSel   (opSel),
    .ctrl    (ctrl)
  );

  bfDatapath #(.DW(DATA_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .srcA     (srcA),
    .srcB     (srcB),
    .immField (immField),
    .immSel   (immSel),
    .outValid (outValid),
    .result   (result)
  );
endmodule

// File: tb/tb_bitfield_unit.sv
`timescale 1ns/1ps
module tb_bitfield_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  opSel = '0;
  logic [31:0] srcA = '0, srcB = '0;
  logic [15:0] immField = '0;
  logic        immSel = 1'b0;
  logic        outValid;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic [31:0] lastExp = '0;

  always #5 clk = ~clk;

  bitfield_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .srcA(srcA), .srcB(srcB), .immField(immField), .immSel(immSel),
    .outValid(outValid), .result(result)
  );

  function automatic logic [9:0] spc(input int w, input int o);
    return {w[4:0], o[4:0]};
  endfunction

  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [15:0] im, input logic isImm);
    logic [9:0] d;
    int o, w, top;
    logic [31:0] r;
    d = isImm ? im[9:0] : b[9:0];
    o = int'(d[4:0]);
    w = (d[9:5] == 0) ? 32 : int'(d[9:5]);
    r = '0;
    case (op)
      4'd0, 4'd1: begin
        top = -1;
        for (int i = 0; i < w; i++)
          if (o + i < 32) begin r[i] = a[o + i]; top = i; end
        if (op == 4'd1 && r[top])
          for (int i = top + 1; i < 32; i++) r[i] = 1'b1;
      end
      4'd2: for (int i = 0; i < w; i++) if (o + i < 32) r[o + i] = a[i];
      4'd3: r = a & b;
      4'd4: r = a & ~b;
      4'd5: r = a & {16'hFFFF, im};
      4'd6: r = a & {im, 16'hFFFF};
      4'd7: r = a & {16'h0000, im};
      4'd8: r = a & {im, 16'h0000};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic isImm, input string tag);
    @(negedge clk);
    inValid = 1'b1; opSel = op; srcA = a; srcB = b; immField = im; immSel = isImm;
    expQ.push_back(model(op, a, b, im, isImm));
    tagQ.push_back(tag);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) check(1'b0, "R1 unexpected result", result, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        lastExp = e;
        check(result === e, t, result, e);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    repeat (2) @(negedge clk);
    check(outValid === 1'b0, "R1 reset outValid", {31'b0, outValid}, 32'h0);
    check(result === 32'h0, "R1 reset result", result, 32'h0);
    rstN = 1'b1;

    drive(4'd0, 32'hDEADBEEF, {22'h0, spc(8, 4)}, 16'h0, 1'b0, "R4 extu basic");
    drive(4'd0, 32'hF0F0A5C3, 32'hFFFFFC00 | spc(5, 3), 16'h0, 1'b0, "R2 reg desc junk upper bits");
    drive(4'd0, 32'hF0F0A5C3, 32'h0, {6'h3F, spc(5, 3)}, 1'b1, "R2 imm desc junk upper bits");
    drive(4'd0, 32'h12345678, spc(3, 9), {6'h0, spc(20, 1)}, 1'b1, "R2 immSel picks immediate");
    drive(4'd0, 32'hCAFEBABE, {22'h0, spc(0, 0)}, 16'h0, 1'b0, "R3 width zero full word");
    drive(4'd0, 32'hFFFF0000, {22'h0, spc(12, 24)}, 16'h0, 1'b0, "R4 extu field past bit 31");
    drive(4'd1, 32'h000000F0, {22'h0, spc(4, 4)}, 16'h0, 1'b0, "R5 exts negative field");
    drive(4'd1, 32'h00000070, {22'h0, spc(4, 4)}, 16'h0, 1'b0, "R5 exts positive field");
    drive(4'd1, 32'h80000000, {22'h0, spc(12, 24)}, 16'h0, 1'b0, "R5 exts sign from bit 31");
    drive(4'd1, 32'h7F000000, {22'h0, spc(12, 24)}, 16'h0, 1'b0, "R5 exts clipped positive");
    drive(4'd2, 32'h000000AB, {22'h0, spc(8, 12)}, 16'h0, 1'b0, "R6 make basic");
    drive(4'd2, 32'hFFFFFFFF, {22'h0, spc(8, 28)}, 16'h0, 1'b0, "R6 make drops high bits");
    drive(4'd0, 32'h80000001, {22'h0, spc(0, 7)}, 16'h0, 1'b0, "R7 logical right shift");
    drive(4'd1, 32'h80000001, {22'h0, spc(0, 7)}, 16'h0, 1'b0, "R7 arithmetic right shift");
    drive(4'd2, 32'h80000003, {22'h0, spc(0, 5)}, 16'h0, 1'b0, "R7 logical left shift");
    drive(4'd1, 32'h80000000, {22'h0, spc(0, 31)}, 16'h0, 1'b0, "R7 asr by 31");
    drive(4'd3, 32'hF0F0F0F0, 32'h0FF00FF0, 16'h0, 1'b0, "R8 and");
    drive(4'd4, 32'hF0F0F0F0, 32'h0FF00FF0, 16'h0, 1'b0, "R8 and not");
    drive(4'd5, 32'h12345678, 32'h0, 16'h0F0F, 1'b0, "R9 and imm low");
    drive(4'd6, 32'h12345678, 32'h0, 16'h0F0F, 1'b0, "R9 and imm high");
    drive(4'd7, 32'h12345678, 32'h0, 16'hFF00, 1'b0, "R10 mask low");
    drive(4'd8, 32'h12345678, 32'h0, 16'hFF00, 1'b0, "R10 mask high");
    drive(4'd9, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 1'b0, "R11 undefined opcode 9");
    drive(4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 1'b1, "R11 undefined opcode 15");

    seed = 32'h1234ABCD;
    for (int k = 0; k < 60; k++) begin
      logic [31:0] a, b;
      seed = seed * 32'd1664525 + 32'd1013904223; a = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; b = seed;
      drive(4'(k % 9), a, b, b[31:16], b[12], "R4 R5 R6 mixed sweep");
    end

    drive(4'd0, 32'hA5A5A5A5, {22'h0, spc(16, 8)}, 16'h0, 1'b0, "R4 last before idle");
    @(negedge clk);
    inValid = 1'b0; opSel = 4'd3; srcA = 32'hFFFFFFFF; srcB = 32'hFFFFFFFF;
    repeat (3) @(negedge clk);
    check(outValid === 1'b0, "R11 idle outValid low", {31'b0, outValid}, 32'h0);
    check(result === lastExp, "R11 idle result holds", result, lastExp);
    check(expQ.size() == 0, "R1 all results returned", expQ.size(), 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule